// File: doc/BRIEF.md
# Dual-Edge Cleared Watchdog Timer

This block watches a heartbeat line that software toggles to show that the processor is making progress. The heartbeat is brought into the system clock domain through a short synchroniser chain. Any change of the synchronised level clears the timeout counter, whether the change is rising or falling. If the line holds one level for a whole timeout window, the active-low fault output drops. That output is meant to drive a non-maskable interrupt. It stays low until a later heartbeat edge, or the supervisor's reset, clears the counter.

The timeout is counted in prescaled ticks. `PRESCALE_DIV` clock cycles make one tick, and `TIMEOUT_TICKS` ticks make one window. With the defaults, a 50 MHz clock gives a window of about 1.6 s. A supervisor reset-active input holds the counter cleared, so the window only starts once that reset is released. A low-supply flag forces the fault output low while it is active. The output is released the moment the flag drops. The block has no reset output of its own; a timeout is reported only through the fault line.

Top module: `hbw_watchdog`

## Requirements
- R1: After `rst_n` is released with `sup_rst_act` and `low_supply` both 0 and the heartbeat steady, `fault_n` is 1.
- R2: A heartbeat level change applied between clock edges is sampled at the next rising edge (edge 1). It clears the counter at edge 3. If the heartbeat then holds its level, `fault_n` is 1 up to and including edge 2+`TIMEOUT_TICKS`*`PRESCALE_DIV` and 0 from edge 3+`TIMEOUT_TICKS`*`PRESCALE_DIV`.
- R3: A low-to-high heartbeat change clears the counter, and restores `fault_n` to 1 from edge 3 if it was 0.
- R4: A high-to-low heartbeat change clears the counter in the same way as R3.
- R5: Once `fault_n` has fallen on a timeout, it stays 0 for as long as no heartbeat edge and no `sup_rst_act` occur. The counter saturates and does not wrap.
- R6: While `sup_rst_act` is 1, the counter is held at zero and `fault_n` is 1 (when `low_supply` is 0). After `sup_rst_act` falls between edges, `fault_n` falls at edge `TIMEOUT_TICKS`*`PRESCALE_DIV` if the heartbeat stays steady.
- R7: While `low_supply` is 1, `fault_n` is 0 with no clock delay, whatever the counter holds.
- R8: When `low_supply` returns to 0, `fault_n` takes the timeout state at once: 1 if no timeout is pending, 0 if one is.
- R9: A clear and an expiry that land on the same clock edge resolve to a clear, and `fault_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| hb_in | input | 1 | Heartbeat from the processor, asynchronous |
| sup_rst_act | input | 1 | Supervisor reset active, high; holds the counter cleared |
| low_supply | input | 1 | Low-supply flag, high; forces the fault output low |
| fault_n | output | 1 | Active-low watchdog fault, intended for a non-maskable interrupt |

## Verification
Two functions can fall in the same cycle: a heartbeat-driven clear and the tick that completes the window. The bench toggles the heartbeat once, then toggles it again exactly `TIMEOUT_TICKS`*`PRESCALE_DIV` edges later. This lands the second clear on the edge where the first window would expire. The bench samples `fault_n` just after that edge and expects 1, because the clear must win. A second overlap is checked by applying and removing `low_supply` while a timeout is held, to confirm that the release reveals the stored fault rather than a clean state.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
   // Counter width able to hold values 0..max_val, never less than 1 bit
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/hbw_edge_sync.sv
module hbw_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbw_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_chain
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   // Either direction of change counts
   assign edge_pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/hbw_tick_gen.sv
module hbw_tick_gen #(
   parameter int unsigned DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   import hbw_pkg::*;
   localparam int unsigned PW = cnt_width(DIV - 1);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("hbw_tick_gen: DIV must be at least 1");
      end else if (DIV == 1) begin : g_every_cycle
         assign tick = ~restart;
      end else begin : g_divider
         logic [PW-1:0] phase;
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             phase <= '0;
            else if (restart)       phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + 1'b1;
         end
         assign tick = (phase == LAST) && !restart;
      end
   endgenerate
endmodule

// File: rtl/hbw_timeout_ctr.sv
module hbw_timeout_ctr #(
   parameter int unsigned TICKS = 1600,
   localparam int unsigned CW = hbw_pkg::cnt_width(TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          tick,
   output logic [CW-1:0] count,
   output logic          expired
);
   localparam logic [CW-1:0] LIMIT = CW'(TICKS);

   generate
      if (TICKS < 1) begin : g_bad_ticks
         $error("hbw_timeout_ctr: TICKS must be at least 1");
      end
   endgenerate

   // Clear has priority over the counting tick; the count saturates at LIMIT
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clear)                  count <= '0;
      else if (tick && count != LIMIT) count <= count + 1'b1;
   end

   assign expired = (count == LIMIT);
endmodule

// File: rtl/hbw_watchdog.sv
module hbw_watchdog #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned PRESCALE_DIV  = 50000,
   parameter int unsigned TIMEOUT_TICKS = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hb_in,
   input  logic sup_rst_act,
   input  logic low_supply,
   output logic fault_n
);
   localparam int unsigned CW = hbw_pkg::cnt_width(TIMEOUT_TICKS);

   logic          hb_edge;
   logic          clr;
   logic          tick;
   logic [CW-1:0] count;
   logic          expired;

   hbw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (hb_in),
      .edge_pulse (hb_edge)
   );

   assign clr = hb_edge | sup_rst_act;

   hbw_tick_gen #(.DIV(PRESCALE_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clr),
      .tick    (tick)
   );

   hbw_timeout_ctr #(.TICKS(TIMEOUT_TICKS)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clr),
      .tick    (tick),
      .count   (count),
      .expired (expired)
   );

   // Low supply forces the fault without any clock delay
   assign fault_n = ~(expired | low_supply);
endmodule

// File: rtl/hbw_watchdog_chk.sv
module hbw_watchdog_chk #(
   parameter int unsigned TIMEOUT_TICKS = 1600,
   localparam int unsigned CW = hbw_pkg::cnt_width(TIMEOUT_TICKS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sup_rst_act,
   input logic          low_supply,
   input logic          fault_n,
   input logic          hb_edge,
   input logic          tick,
   input logic [CW-1:0] count
);
   // R7
   low_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_supply |-> !fault_n);

   // R6
   rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sup_rst_act |=> (count == '0) && (fault_n || low_supply));

   // R3
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_edge |=> (count == '0));

   // R5
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && !low_supply && !hb_edge && !sup_rst_act) |=> (!fault_n || low_supply));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(TIMEOUT_TICKS));

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_edge && !sup_rst_act && !tick) |=> $stable(count));
endmodule

bind hbw_watchdog hbw_watchdog_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sup_rst_act (sup_rst_act),
   .low_supply  (low_supply),
   .fault_n     (fault_n),
   .hb_edge     (hb_edge),
   .tick        (tick),
   .count       (count)
);

// File: tb/hbw_watchdog_bench.sv
module hbw_watchdog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int TICKS      = 5;
   localparam int WIN        = DIV * TICKS;   // 20 edges

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hb_in = 1'b0;
   logic sup_rst_act = 1'b0;
   logic low_supply = 1'b0;
   logic fault_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbw_watchdog #(.SYNC_STAGES(2), .PRESCALE_DIV(DIV), .TIMEOUT_TICKS(TICKS)) u_hbw_watchdog (
      .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .sup_rst_act(sup_rst_act),
      .low_supply(low_supply), .fault_n(fault_n)
   );

   // Vector table: edges to wait after a heartbeat toggle, expected fault_n
   localparam int NV = 10;
   localparam int VGAP [NV] = '{5, 22, 23, 2, 3, 10, 40, 2, 21, 23};
   localparam bit VEXP [NV] = '{1, 1, 0, 0, 1, 1, 0, 0, 1, 0};

   task automatic check(input logic got, input logic exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: fault_n=%0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog_timer
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, fault_n=%0b expected completion", fault_n);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      wait_edges(3);
      rst_n = 1'b1;
      wait_edges(2);
      // R1: reset state
      check(fault_n, 1'b1, "R1 after reset");

      // Table walk; first toggle is rising (R3), then falling (R4), alternating
      for (int i = 0; i < NV; i++) begin
         hb_in = ~hb_in;
         wait_edges(VGAP[i]);
         check(fault_n, VEXP[i], hb_in ? "R2/R3 rising vector" : "R2/R4 falling vector");
      end

      // R5: saturated counter keeps the fault low for a long time
      wait_edges(300);
      check(fault_n, 1'b0, "R5 held after long idle");

      // R8: low supply released while a timeout is stored keeps fault low
      low_supply = 1'b1;
      #1 check(fault_n, 1'b0, "R7 forced while faulted");
      wait_edges(2);
      low_supply = 1'b0;
      #1 check(fault_n, 1'b0, "R8 release reveals stored timeout");

      // R6: supervisor reset clears a stored fault on the next edge and holds
      @(negedge clk);
      sup_rst_act = 1'b1;
      wait_edges(1);
      check(fault_n, 1'b1, "R6 clear by supervisor reset");
      wait_edges(50);
      check(fault_n, 1'b1, "R6 held over long reset");
      sup_rst_act = 1'b0;
      wait_edges(WIN - 1);
      check(fault_n, 1'b1, "R6 window not yet elapsed");
      wait_edges(1);
      check(fault_n, 1'b0, "R6 timeout from reset release");

      // R7 / R8 with no pending timeout
      hb_in = ~hb_in;
      wait_edges(5);
      check(fault_n, 1'b1, "R3 toggle restored");
      low_supply = 1'b1;
      #1 check(fault_n, 1'b0, "R7 immediate force");
      wait_edges(3);
      check(fault_n, 1'b0, "R7 held while low");
      low_supply = 1'b0;
      #1 check(fault_n, 1'b1, "R8 immediate release");

      // R9: second clear lands on the first window's expiry edge
      hb_in = ~hb_in;
      wait_edges(WIN);
      hb_in = ~hb_in;
      wait_edges(3);
      check(fault_n, 1'b1, "R9 clear wins over expiry");
      wait_edges(WIN - 1);
      check(fault_n, 1'b1, "R9 new window not elapsed");
      wait_edges(1);
      check(fault_n, 1'b0, "R9 new window expiry");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule